// File: doc/BRIEF.md
# Masked fuse row reader

This block serves read requests aimed at a one-time-programmable fuse store. A bus write to the read-address register names an array and a row. The block checks that request against a fixed permission table. If the row may be read, it fetches the 32-bit row from the fuse array over a request/response handshake and keeps only the columns the table allows. The filtered word goes into a read-data register. A done flag or an error flag reports the outcome.

The primary array (select 0) has a built-in column-permission ROM with one entry per row. An all-zero entry denies the row outright. Selects 2 and 3 address the helper-data arrays: the block forwards them to physical arrays 1 and 2 and reads them unmasked. Select 1 is always refused. A refused request never reaches the fuse array. Read-data drops to zero and the error flag rises on the following clock.

Top module: `fuse_row_reader`

## Requirements
- R1: After reset, read-data is 0, both the done and error flags are 0, the fetch request is low and response-ready is low.
- R2: The request word takes the row from bits [10:5] and the array select from bits [12:11]. Bits [4:0] are reserved and have no effect on the row fetched or on the result.
- R3: For select 0, the permitted columns of each row are as follows. Row 0 allows columns 28 to 31. Rows 8 to 15, 20, 22, 23 and 40 to 63 allow all columns. Row 16 allows columns 0 to 7 and 10 to 16. Row 17 allows columns 0 to 2. Row 21 allows columns 0 to 23 and 29 to 31.
- R4: A select-0 row with no permitted column is denied. On the clock after the write, read-data becomes 0, error becomes 1 and done becomes 0, and no fetch request is raised.
- R5: Select 1 is denied with the same outcome as R4.
- R6: Selects 2 and 3 issue a fetch to physical array 1 and 2 respectively, at the same row, and every column of the returned row is kept.
- R7: On a permitted read, in the cycle after the response is accepted (response-valid and response-ready both high), read-data equals the returned row ANDed with the row's mask, done is 1 and error is 0.
- R8: Handshake: the fetch request stays high, with array and row unchanged, until request-ready is seen. Response-ready is high only after the request has been accepted, and it stays high until response-valid arrives. Stalls on either side of the array are allowed.
- R9: While a fetch is in flight, read-data and both flags hold their previous values. Read-data has no bus write path and changes only through R4, R5 and R7.
- R10: A read-address write that arrives while a fetch is in flight is ignored. It starts no fetch, causes no denial, and does not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr_en | input | 1 | Bus write strobe for the read-address register |
| addr_wr_data | input | 13 | Read-address word: select [12:11], row [10:5], reserved [4:0] |
| rd_data | output | 32 | Read-data register (read-only) |
| rd_done | output | 1 | Last read completed with data |
| rd_error | output | 1 | Last read was denied |
| arr_req_valid | output | 1 | Row fetch request to the fuse array |
| arr_req_ready | input | 1 | Fuse array accepts the request |
| arr_req_sel | output | 2 | Physical array index of the fetch |
| arr_req_row | output | 6 | Row index of the fetch |
| arr_rsp_valid | input | 1 | Fuse array returns row data |
| arr_rsp_ready | output | 1 | Block waits for row data |
| arr_rsp_data | input | 32 | Returned row contents |

## Verification
Every one of the 64 select-0 rows is read once. This separates rows whose masks are partial, full or empty, and the array model returns a distinct word per array and row, so any wrong mask bit shows up in read-data. Selects 2 and 3 are read with dense data to confirm that both the remapped physical index and the mask bypass are correct. Select 1 is read to confirm it is refused. Nonzero reserved bits, varying request and response stalls, and a write injected mid-fetch separate correct field decoding and handshake holding from designs that start early, restart, or leak a later request into the result.

// File: rtl/frr_pkg.sv
package frr_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_e;

  // Contiguous run of set bits from column lo to column hi inclusive
  function automatic logic [31:0] col_span(input int unsigned lo, input int unsigned hi);
    logic [63:0] w;
    w = (64'd1 << (hi + 1)) - (64'd1 << lo);
    return w[31:0];
  endfunction

  // Column-permission word for a row of the primary array; zero denies the row
  function automatic logic [31:0] row_cols(input int unsigned row);
    logic [31:0] m;
    m = '0;
    if (row == 0)                    m = col_span(28, 31);
    else if (row >= 8 && row <= 15)  m = col_span(0, 31);
    else if (row == 16)              m = col_span(0, 7) | col_span(10, 16);
    else if (row == 17)              m = col_span(0, 2);
    else if (row == 20)              m = col_span(0, 31);
    else if (row == 21)              m = col_span(0, 23) | col_span(29, 31);
    else if (row == 22 || row == 23) m = col_span(0, 31);
    else if (row >= 40 && row <= 63) m = col_span(0, 31);
    return m;
  endfunction

endpackage

// File: rtl/frr_addr_decode.sv
module frr_addr_decode #(
  parameter int ROW_W  = 6,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ROW_W-1:0]  row,
  output logic [SEL_W-1:0]  phys_sel,
  output logic              permit,
  output logic [DATA_W-1:0] mask
);
  localparam int N_ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] perm_rom [N_ROWS];

  // Permission ROM computed per row at elaboration
  for (genvar g = 0; g < N_ROWS; g++) begin : g_rom
    assign perm_rom[g] = DATA_W'(frr_pkg::row_cols(g));
  end

  always_comb begin
    phys_sel = '0;
    permit   = 1'b0;
    mask     = '0;
    if (sel == SEL_W'(0)) begin
      mask   = perm_rom[row];
      permit = |perm_rom[row];
    end else if (sel == SEL_W'(1)) begin
      permit = 1'b0;
    end else begin
      phys_sel = sel - SEL_W'(1);
      mask     = '1;
      permit   = 1'b1;
    end
  end
endmodule

// File: rtl/frr_fetch_ctrl.sv
module frr_fetch_ctrl #(
  parameter int ROW_W  = 6,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  start_sel,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [DATA_W-1:0] start_mask,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SEL_W-1:0]  req_sel,
  output logic [ROW_W-1:0]  req_row,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              complete,
  output logic [DATA_W-1:0] masked_data
);
  import frr_pkg::*;

  fetch_state_e      state_q;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      req_sel <= '0;
      req_row <= '0;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (start) begin
          state_q <= FS_REQ;
          req_sel <= start_sel;
          req_row <= start_row;
          mask_q  <= start_mask;
        end
        FS_REQ:  if (req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (rsp_valid) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != FS_IDLE);
  assign req_valid   = (state_q == FS_REQ);
  assign rsp_ready   = (state_q == FS_WAIT);
  assign complete    = rsp_valid && rsp_ready;
  assign masked_data = rsp_data & mask_q;

  // R8: a stalled request keeps its contents
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_sel) && $stable(req_row));

  // R8: an accepted request is followed by waiting for data
  a_r8_accept_wait: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_ready && !req_valid);
endmodule

// File: rtl/fuse_row_reader.sv
module fuse_row_reader #(
  parameter int ROW_W  = 6,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 32,
  localparam int ROW_LSB = $clog2(DATA_W),
  localparam int SEL_LSB = ROW_LSB + ROW_W,
  localparam int ADDR_W  = SEL_LSB + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              rd_error,
  output logic              arr_req_valid,
  input  logic              arr_req_ready,
  output logic [SEL_W-1:0]  arr_req_sel,
  output logic [ROW_W-1:0]  arr_req_row,
  input  logic              arr_rsp_valid,
  output logic              arr_rsp_ready,
  input  logic [DATA_W-1:0] arr_rsp_data
);
  logic [SEL_W-1:0]  dec_sel;
  logic [ROW_W-1:0]  dec_row;
  logic [SEL_W-1:0]  dec_phys;
  logic              dec_permit;
  logic [DATA_W-1:0] dec_mask;
  logic              busy, complete, accept, start, deny;
  logic [DATA_W-1:0] masked_data;
  logic              unused_rsvd;

  assign dec_sel     = addr_wr_data[SEL_LSB +: SEL_W];
  assign dec_row     = addr_wr_data[ROW_LSB +: ROW_W];
  assign unused_rsvd = ^addr_wr_data[ROW_LSB-1:0];

  frr_addr_decode #(.ROW_W(ROW_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_dec (
    .sel      (dec_sel),
    .row      (dec_row),
    .phys_sel (dec_phys),
    .permit   (dec_permit),
    .mask     (dec_mask)
  );

  assign accept = addr_wr_en && !busy;
  assign start  = accept && dec_permit;
  assign deny   = accept && !dec_permit;

  frr_fetch_ctrl #(.ROW_W(ROW_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_sel   (dec_phys),
    .start_row   (dec_row),
    .start_mask  (dec_mask),
    .busy        (busy),
    .req_valid   (arr_req_valid),
    .req_ready   (arr_req_ready),
    .req_sel     (arr_req_sel),
    .req_row     (arr_req_row),
    .rsp_valid   (arr_rsp_valid),
    .rsp_ready   (arr_rsp_ready),
    .rsp_data    (arr_rsp_data),
    .complete    (complete),
    .masked_data (masked_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_done  <= 1'b0;
      rd_error <= 1'b0;
    end else if (complete) begin
      rd_data  <= masked_data;
      rd_done  <= 1'b1;
      rd_error <= 1'b0;
    end else if (deny) begin
      rd_data  <= '0;
      rd_done  <= 1'b0;
      rd_error <= 1'b1;
    end
  end

  // R4/R5: a refused request raises no fetch and reports an error
  a_r4_deny_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> !arr_req_valid && rd_error && (rd_data == '0));

  // R7: the two outcome flags are never both set
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !rd_error);

  // R9: results hold while waiting for row data
  a_r9_hold_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rsp_ready && !arr_rsp_valid |=> $stable(rd_data) && $stable(rd_done) && $stable(rd_error));

  // R10: writes during a fetch do not end or restart it
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rsp_ready && !arr_rsp_valid && addr_wr_en |=> arr_rsp_ready && !arr_req_valid);
endmodule

// File: tb/sim_fuse_row_reader.sv
`timescale 1ns/1ps
module sim_fuse_row_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr_en = 1'b0;
  logic [12:0] addr_wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_done, rd_error;
  logic        arr_req_valid, arr_rsp_ready;
  logic        arr_req_ready = 1'b0;
  logic [1:0]  arr_req_sel;
  logic [5:0]  arr_req_row;
  logic        arr_rsp_valid = 1'b0;
  logic [31:0] arr_rsp_data = '0;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  fuse_row_reader u0 (
    .clk(clk), .rst_n(rst_n),
    .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .rd_data(rd_data), .rd_done(rd_done), .rd_error(rd_error),
    .arr_req_valid(arr_req_valid), .arr_req_ready(arr_req_ready),
    .arr_req_sel(arr_req_sel), .arr_req_row(arr_req_row),
    .arr_rsp_valid(arr_rsp_valid), .arr_rsp_ready(arr_rsp_ready),
    .arr_rsp_data(arr_rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Array content model: distinct word per physical array and row
  function automatic logic [31:0] fuse_word(input int p, input int r);
    logic [31:0] v;
    v = 32'h9E37_79B9 * 32'(p * 64 + r + 1);
    return v ^ 32'h5A5A_0F0F;
  endfunction

  // Expected permission mask for select 0, written from R3 as column lists
  function automatic logic [31:0] exp_mask(input int r);
    logic [31:0] m;
    m = '0;
    case (r)
      0:  for (int c = 28; c < 32; c++) m[c] = 1'b1;
      16: begin
        for (int c = 0; c < 8; c++)   m[c] = 1'b1;
        for (int c = 10; c < 17; c++) m[c] = 1'b1;
      end
      17: m = 32'h0000_0007;
      21: begin
        for (int c = 0; c < 24; c++)  m[c] = 1'b1;
        for (int c = 29; c < 32; c++) m[c] = 1'b1;
      end
      default: if ((r >= 8 && r <= 15) || r == 20 || r == 22 || r == 23 || r >= 40) m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

  task automatic write_addr(input int sel, input int row, input int rsvd);
    addr_wr_en   = 1'b1;
    addr_wr_data = {2'(sel), 6'(row), 5'(rsvd)};
    tick();
    addr_wr_en   = 1'b0;
  endtask

  task automatic t_reset();
    check(rd_data == 0, "R1 rd_data", rd_data, 0);
    check(rd_done == 0 && rd_error == 0, "R1 flags", {30'd0, rd_done, rd_error}, 0);
    check(!arr_req_valid && !arr_rsp_ready, "R1 handshake idle", {30'd0, arr_req_valid, arr_rsp_ready}, 0);
  endtask

  // Denied read (R4 for select 0, R5 for select 1)
  task automatic t_denied(input int sel, input int row, input string tag);
    write_addr(sel, row, 5'h15);
    check(rd_data == 0, {tag, " rd_data zero"}, rd_data, 0);
    check(rd_error == 1 && rd_done == 0, {tag, " error set done clear"}, {30'd0, rd_done, rd_error}, 32'd1);
    check(!arr_req_valid, {tag, " no fetch"}, {31'd0, arr_req_valid}, 0);
    tick();
    check(!arr_req_valid && !arr_rsp_ready, {tag, " stays idle"}, {30'd0, arr_req_valid, arr_rsp_ready}, 0);
  endtask

  // Permitted read with request stall, response latency and optional mid-fetch write
  task automatic t_permitted(input int sel, input int row, input int rsvd, input int stall,
                             input int lat, input bit inject, input string tag);
    int          p;
    logic [31:0] m, prev_d;
    logic        prev_done, prev_err;
    p = (sel == 0) ? 0 : sel - 1;
    m = (sel == 0) ? exp_mask(row) : 32'hFFFF_FFFF;
    prev_d = rd_data; prev_done = rd_done; prev_err = rd_error;
    write_addr(sel, row, rsvd);
    check(arr_req_valid, {tag, " R8 request raised"}, {31'd0, arr_req_valid}, 1);
    check(arr_req_sel == 2'(p), {tag, " R6 physical array"}, {30'd0, arr_req_sel}, 32'(p));
    check(arr_req_row == 6'(row), {tag, " R2 row field"}, {26'd0, arr_req_row}, 32'(row));
    for (int i = 0; i < stall; i++) begin
      tick();
      check(arr_req_valid && arr_req_sel == 2'(p) && arr_req_row == 6'(row) && !arr_rsp_ready,
            {tag, " R8 request held"}, {23'd0, arr_req_valid, arr_req_sel, arr_req_row}, {23'd0, 1'b1, 2'(p), 6'(row)});
    end
    arr_req_ready = 1'b1;
    tick();
    arr_req_ready = 1'b0;
    check(arr_rsp_ready && !arr_req_valid, {tag, " R8 waiting for data"}, {30'd0, arr_rsp_ready, arr_req_valid}, 32'd2);
    for (int i = 0; i < lat; i++) begin
      if (inject && i == 0) begin
        write_addr(1, 3, 0);
      end else begin
        tick();
      end
      check(rd_data == prev_d && rd_done == prev_done && rd_error == prev_err,
            {tag, " R9 result held in flight"}, rd_data, prev_d);
      check(arr_rsp_ready && !arr_req_valid, {tag, " R10 fetch undisturbed"}, {30'd0, arr_rsp_ready, arr_req_valid}, 32'd2);
    end
    arr_rsp_valid = 1'b1;
    arr_rsp_data  = fuse_word(p, row);
    tick();
    arr_rsp_valid = 1'b0;
    arr_rsp_data  = '0;
    check(rd_data == (fuse_word(p, row) & m), {tag, " R7 masked data"}, rd_data, fuse_word(p, row) & m);
    check(rd_done == 1 && rd_error == 0, {tag, " R7 done set error clear"}, {30'd0, rd_done, rd_error}, 32'd2);
    check(!arr_req_valid && !arr_rsp_ready, {tag, " R10 back to idle"}, {30'd0, arr_req_valid, arr_rsp_ready}, 0);
  endtask

  task automatic t_all_rows_primary();
    for (int r = 0; r < 64; r++) begin
      if (exp_mask(r) == 0) t_denied(0, r, "R4 sel0 denied row");
      else t_permitted(0, r, r % 32, r % 3, 1 + (r % 2), 1'b0, "R3 sel0 row");
    end
  endtask

  task automatic t_helper_arrays();
    t_permitted(2, 5, 0, 0, 1, 1'b0, "R6 sel2");
    t_permitted(3, 63, 31, 2, 3, 1'b0, "R6 sel3");
    t_permitted(2, 0, 7, 1, 0, 1'b0, "R6 sel2 row0 unmasked");
  endtask

  task automatic t_sel1();
    t_denied(1, 8, "R5 sel1");
    t_denied(1, 40, "R5 sel1");
  endtask

  task automatic t_write_in_flight();
    t_permitted(0, 21, 0, 1, 3, 1'b1, "R10 write during fetch");
  endtask

  task automatic t_reserved_bits();
    t_permitted(0, 16, 5'h1F, 0, 1, 1'b0, "R2 reserved bits set");
    t_permitted(0, 16, 5'h00, 0, 1, 1'b0, "R2 reserved bits clear");
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    tick();
    tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_all_rows_primary();
    t_sel1();
    t_helper_arrays();
    t_reserved_bits();
    t_write_in_flight();
    t_denied(0, 30, "R4 after good read");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule